// File: doc/BRIEF.md
# Daisy-Chainable Stereo Level Serial Port

This block is the write-only control port of a two-channel level controller. A host frames a control word by pulling the active-low select line low, then clocks data bits in on the rising edge of a serial clock. When select returns high, the block takes the last sixteen bits it shifted in and presents them as two registered 8-bit level values, one per channel. It also raises a one-cycle update strobe so that downstream logic can start a level transition.

The block has a serial data output so that several devices can be chained on one select line. This output shifts out the bits that were previously held in the shift register and launches a new bit on each falling serial clock edge. While the device is deselected, an output-enable tells the pad to hold the line in high impedance. All logic runs in one system clock domain that oversamples the select, clock and data lines. The system clock must be at least four times faster than the serial clock.

Top module: `svp_level_port`

## Requirements
- R1: After reset, both level outputs read zero, the update strobe is low, the output-enable is low, and the internal 16-bit shift register holds zero. The first frame after reset therefore shifts out sixteen zero bits.
- R2: A data bit is captured on each rising serial clock edge only while select is low. Serial clock edges while select is high leave the shift register unchanged.
- R3: In a 16-bit frame the first eight bits received, most significant bit first, become the right level (`level_r_o`). The next eight bits become the left level (`level_l_o`).
- R4: The level outputs hold their value from the start of a frame until the rising edge of select. They change only at that edge.
- R5: When select falls, the serial output presents bit 15 of the shift register. After each falling serial clock edge it presents the new bit 15. A chained device sampling on rising edges therefore receives the previous register contents, most significant bit first, followed by the bits received in this frame.
- R6: The output-enable is low while select is high and high while select is low. `sdo_o` is forced to 0 when the output-enable is low.
- R7: A frame with a count other than 16 still loads the register on the rising edge of select. The right level takes register bits 15:8 and the left level takes bits 7:0, which are the last sixteen bits shifted in. No error is signalled.
- R8: Each load of the level registers produces exactly one `upd_o` pulse, one system clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out for chaining |
| sdo_oe_o | output | 1 | Output-enable for the serial output pad. Low means high impedance |
| level_r_o | output | LVL_W | Right channel level |
| level_l_o | output | LVL_W | Left channel level |
| upd_o | output | 1 | One-cycle pulse when the levels load |

## Verification
The bench builds the block with its defaults: 8-bit levels, a 16-bit word and two synchronizer stages. It drives the serial clock at one tenth of the system clock, which keeps the oversampling well above the four-times minimum. With a 16-bit word, frames of 0, 5, 20 and random lengths up to 40 bits are short enough to test. These reach the cases where chained output carries both old and new bits, and loads after short and long frames. Serial clocks sent while deselected, followed by an empty frame, show at the level outputs that those edges shifted nothing.

// File: rtl/svp_pkg.sv
package svp_pkg;
  // index of each oversampled line in the synchronizer bank
  typedef enum int unsigned {
    LN_SCLK = 0,
    LN_SEL  = 1,
    LN_SDI  = 2
  } svp_line_e;

  localparam int SVP_NLINES = 3;
  localparam int SVP_NEDGE  = 2;  // lines that need edge detection: sclk, sel
endpackage

// File: rtl/svp_sync.sv
module svp_sync #(
  parameter int            N       = 3,
  parameter int            STAGES  = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign lvl_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/svp_edge.sv
module svp_edge #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/svp_shift.sv
module svp_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,       // synchronized select level, 1 = idle
  input  logic              sel_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sh_q;
  logic              sdo_q;
  logic              shift_en, launch_en;

  assign shift_en  = sclk_rise_i & ~sel_i;
  // preload on select fall so the oldest bit is ready before the first rise
  assign launch_en = sel_fall_i | (sclk_fall_i & ~sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sdo_q <= 1'b0;
    else if (launch_en) sdo_q <= sh_q[WORD_W-1];
  end

  assign word_o = sh_q;
  assign sdo_o  = sdo_q;

  p_shift_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_rise_i || sel_i) |=> $stable(word_o));

  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise_i && !sel_i) |=> word_o[0] == $past(sdi_i));

  p_sdo_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_fall_i || (sclk_fall_i && !sel_i)) |=> $stable(sdo_o));
endmodule

// File: rtl/svp_ctrl.sv
module svp_ctrl #(
  parameter int LVL_W = 8,
  localparam int WORD_W = 2 * LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [LVL_W-1:0]  level_r_o,
  output logic [LVL_W-1:0]  level_l_o,
  output logic              upd_o
);
  logic [LVL_W-1:0] lvl_r_q, lvl_l_q;
  logic             upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_r_q <= '0;
      lvl_l_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) begin
        lvl_r_q <= word_i[WORD_W-1:LVL_W];  // first byte in
        lvl_l_q <= word_i[LVL_W-1:0];
      end
    end
  end

  assign level_r_o = lvl_r_q;
  assign level_l_o = lvl_l_q;
  assign upd_o     = upd_q;

  p_lvl_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(level_r_o) && $stable(level_l_o)));

  p_lvl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (level_r_o == $past(word_i[WORD_W-1:LVL_W]) &&
                level_l_o == $past(word_i[LVL_W-1:0])));

  p_upd_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);
endmodule

// File: rtl/svp_level_port.sv
module svp_level_port
  import svp_pkg::*;
#(
  parameter int LVL_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [LVL_W-1:0] level_r_o,
  output logic [LVL_W-1:0] level_l_o,
  output logic             upd_o
);
  localparam int WORD_W = 2 * LVL_W;
  localparam logic [SVP_NLINES-1:0] SYNC_RST = SVP_NLINES'(1) << LN_SEL;
  localparam logic [SVP_NEDGE-1:0]  EDGE_RST = SVP_NEDGE'(2);  // sel idles high

  logic [SVP_NLINES-1:0] raw, lvl;
  logic [SVP_NEDGE-1:0]  edge_lvl, rise, fall;
  logic [WORD_W-1:0]     word;
  logic                  sdo_q, oe;

  assign raw[LN_SCLK] = sclk_i;
  assign raw[LN_SEL]  = sel_ni;
  assign raw[LN_SDI]  = sdi_i;

  // data goes through the same depth as the clock so capture stays aligned
  svp_sync #(.N(SVP_NLINES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw),
    .lvl_o  (lvl)
  );

  assign edge_lvl = {lvl[LN_SEL], lvl[LN_SCLK]};

  svp_edge #(.N(SVP_NEDGE), .RST_VAL(EDGE_RST)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (edge_lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  svp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (lvl[LN_SEL]),
    .sel_fall_i (fall[1]),
    .sclk_rise_i(rise[0]),
    .sclk_fall_i(fall[0]),
    .sdi_i      (lvl[LN_SDI]),
    .word_o     (word),
    .sdo_o      (sdo_q)
  );

  svp_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rise[1]),
    .word_i   (word),
    .level_r_o(level_r_o),
    .level_l_o(level_l_o),
    .upd_o    (upd_o)
  );

  assign oe       = ~lvl[LN_SEL];
  assign sdo_oe_o = oe;
  assign sdo_o    = oe & sdo_q;

  p_sdo_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  p_upd_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> !sdo_oe_o);
endmodule

// File: tb/tb_svp_level_port.sv
module tb_svp_level_port;
  localparam int LVL_W  = 8;
  localparam int WORD_W = 2 * LVL_W;
  localparam int HALF   = 5;

  logic clk = 1'b0, rst_ni = 1'b0, sel_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo_o, sdo_oe_o, upd_o;
  logic [LVL_W-1:0] level_r_o, level_l_o;

  int n_chk = 0, n_fail = 0, upd_cnt = 0, upd_wide = 0, cyc = 0;
  logic upd_q = 1'b0;
  logic [WORD_W-1:0] model = '0, exp_word = '0;

  always #10 clk = ~clk;

  svp_level_port #(.LVL_W(LVL_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_ni(sel_ni), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .level_r_o(level_r_o),
    .level_l_o(level_l_o), .upd_o(upd_o)
  );

  always @(negedge clk) begin
    if (upd_o) upd_cnt++;
    if (upd_o && upd_q) upd_wide++;
    upd_q = upd_o;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send nbits, MSB of the nbits-wide field first; exp_word tracks R3/R7
  task automatic frame(input int nbits, input logic [63:0] bits, input string req);
    int c0;
    c0 = upd_cnt;
    sel_ni = 1'b0;
    tick(6);
    chk(sdo_oe_o == 1'b1, "R6", 32'(sdo_oe_o), 1);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[nbits-1-i];
      chk(sdo_o == model[WORD_W-1], "R5", 32'(sdo_o), 32'(model[WORD_W-1]));
      tick(1);
      sclk = 1'b1;
      tick(HALF);
      model = {model[WORD_W-2:0], sdi};
      sclk = 1'b0;
      tick(HALF);
      if (i == nbits / 2)
        chk({level_r_o, level_l_o} == exp_word, "R4", 32'({level_r_o, level_l_o}), 32'(exp_word));
    end
    chk({level_r_o, level_l_o} == exp_word, "R4", 32'({level_r_o, level_l_o}), 32'(exp_word));
    sel_ni = 1'b1;
    tick(8);
    exp_word = model;
    chk(level_r_o == exp_word[WORD_W-1:LVL_W], req, 32'(level_r_o), 32'(exp_word[WORD_W-1:LVL_W]));
    chk(level_l_o == exp_word[LVL_W-1:0], req, 32'(level_l_o), 32'(exp_word[LVL_W-1:0]));
    chk(upd_cnt == c0 + 1, "R8", 32'(upd_cnt), 32'(c0 + 1));
    chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R6", 32'({sdo_oe_o, sdo_o}), 0);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'($urandom);
      sclk = 1'b1;
      tick(HALF);
      chk(sdo_oe_o == 1'b0, "R6", 32'(sdo_oe_o), 0);
      sclk = 1'b0;
      tick(HALF);
    end
    chk({level_r_o, level_l_o} == exp_word, "R2", 32'({level_r_o, level_l_o}), 32'(exp_word));
  endtask

  initial begin
    void'($urandom(32'd1729));
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    chk(level_r_o == '0 && level_l_o == '0, "R1", 32'({level_r_o, level_l_o}), 0);
    chk(upd_o == 1'b0, "R1", 32'(upd_o), 0);
    chk(sdo_oe_o == 1'b0, "R1", 32'(sdo_oe_o), 0);

    // R1 shift register zero shows up as sixteen zero bits on sdo (R5 checks)
    frame(16, 64'hA55A, "R3");
    frame(16, 64'h00FF, "R3");
    frame(16, 64'hFF00, "R3");
    frame(16, 64'h8001, "R3");

    // R2: edges while deselected are ignored, empty frame reloads old word
    idle_clocks(12);
    frame(0, 64'h0, "R2");

    // R7: short and long frames
    frame(5, 64'h15, "R7");
    frame(20, 64'hC3A5F, "R7");
    frame(1, 64'h1, "R7");

    for (int k = 0; k < 30; k++) begin
      logic [63:0] b;
      int n;
      b = {$urandom, $urandom};
      if (k % 4 == 3) begin
        n = 1 + int'($urandom % 40);
        frame(n, b, "R7");
      end else begin
        frame(16, b, "R3");
      end
      if (k % 7 == 0) idle_clocks(3);
    end

    chk(upd_wide == 0, "R8", 32'(upd_wide), 0);
    summary();
    $finish;
  end
endmodule